// File: doc/BRIEF.md
# HDLC receive frame processor

This block sits behind a flag and zero-deletion stage on the receive side of an HDLC link. It gets one strobe per destuffed data bit, plus single-cycle strobes when a flag or an abort sequence is recognised. From these it rebuilds the frame bytes, least significant bit first. The last 16 bits before a closing flag are always treated as the frame check sequence. A 16-bit delay line therefore sits between the incoming bits and the byte output, so that checksum bits never reach the downstream FIFO.

Each byte leaving the block carries a 2-bit position tag. The tag marks the byte as the opening byte of a packet, a middle byte, or the final byte. A final byte is flagged good or bad from the CRC result, the frame length and any abort. A receive-enable input switches reception on at once, but reception starts only at the next flag. Dropping the enable stops reception at once if nothing of the current packet has been written yet. Otherwise reception stops once that packet has been fully written. The checksum field of every closed frame is kept for readback.

Top module: `hdlc_rx_frame`

## Requirements
- R1: While rst_ni is low, byte_vld_o, byte_o, tag_o and fcs_o are all zero, and the receiver is off until rx_en_i is seen high.
- R2: Data bits are packed first-received into bit 0. The final 16 bits before a closing flag never appear on byte_o. tag_o encodes 2'b01 for the first byte of a packet, 2'b00 for a middle byte, 2'b10 for the last byte of a good packet and 2'b11 for the last byte of a bad packet. Every packet written starts with 2'b01 and ends with 2'b10 or 2'b11.
- R3: A frame closed by a flag gets the good last-byte tag 2'b10 only if three conditions hold. It holds at least 32 bits. Its length is a multiple of 8. Its CRC residue equals 16'hF0B8, where the CRC is x^16+x^12+x^5+1 run least-significant-bit first from a preset of 16'hFFFF over all bits including the checksum.
- R4: A frame of 32 or more aligned bits whose CRC residue is wrong has all its bytes written, with the last tagged 2'b11.
- R5: An abort strobe ends the frame. If any byte of it was written, the held byte goes out tagged 2'b11. After the abort, bits are ignored until the next flag.
- R6: A frame shorter than 32 bits produces no output at all. A frame of 32 or more bits whose length is not a whole number of bytes ends with tag 2'b11.
- R7: After rx_en_i rises, bits arriving before the first flag are ignored, so a frame already under way is dropped.
- R8: If rx_en_i falls while no byte of the current frame has been written, reception stops at once. The rest of that frame, including its closing flag, leaves byte_o and fcs_o untouched.
- R9: If rx_en_i falls after a byte of the current frame has been written, the frame still completes with its normal tags. Frames that follow are ignored while rx_en_i stays low.
- R10: At a closing flag ending a frame of at least 16 bits, fcs_o takes the last 16 received bits, the first of them in bit 15. fcs_o changes at no other time.
- R11: One flag both closes a frame and opens the next one.
- R12: byte_vld_o rises only in the cycle after a bit, flag or abort strobe, and each strobe produces at most one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| bit_vld_i | input | 1 | Strobe: bit_i holds a destuffed data bit |
| bit_i | input | 1 | Received data bit |
| flag_i | input | 1 | Strobe: a flag sequence was seen |
| abort_i | input | 1 | Strobe: an abort sequence was seen |
| byte_vld_o | output | 1 | Byte write strobe toward the FIFO |
| byte_o | output | 8 | Byte written |
| tag_o | output | 2 | Position and status tag of the byte |
| fcs_o | output | 16 | Checksum field of the last closed frame |

## Verification
The hardest case to reach is the boundary of the disable rule. It requires dropping the enable in the narrow stretch between the opening flag and the 32nd bit, when bytes are held in the delay line but none has been written yet, and also just after that stretch. The stimulus drops rx_en_i at a chosen bit index inside a frame: once at bit 20 and once at bit 45. It then checks that the first frame vanishes, leaving the checksum readback untouched, and that the second frame arrives whole. Randomly sized frames with random single-bit corruption, shared flags and random idle gaps between bits cover the tag logic around that case.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    TAG_MID      = 2'b00,
    TAG_FIRST    = 2'b01,
    TAG_LAST_OK  = 2'b10,
    TAG_LAST_BAD = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    RX_OFF   = 2'b00,
    RX_HUNT  = 2'b01,
    RX_FRAME = 2'b10
  } rx_st_e;

  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE   = 16'hF0B8;

endpackage

// File: rtl/hdlc_rx_hold.sv
// Bit history: assembles bytes while holding back the trailing FCS window.
module hdlc_rx_hold #(
  parameter int BYTE_W   = 8,
  parameter int FCS_W    = 16,
  parameter int MIN_BITS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              byte_rdy_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [FCS_W-1:0]  fcs_o,
  output logic              fcs_full_o,
  output logic              long_o,
  output logic              aligned_o
);
  localparam int HIST_W = BYTE_W + FCS_W - 1;
  localparam int PH_W   = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int CNT_W  = $clog2(MIN_BITS + 1);

  logic [HIST_W-1:0] hist_q;
  logic [PH_W-1:0]   ph_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      ph_q   <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      hist_q <= '0;
      ph_q   <= '0;
      cnt_q  <= '0;
    end else if (shift_i) begin
      hist_q <= {hist_q[HIST_W-2:0], bit_i};
      ph_q   <= (ph_q == PH_W'(BYTE_W - 1)) ? '0 : ph_q + 1'b1;
      if (cnt_q != CNT_W'(MIN_BITS)) cnt_q <= cnt_q + 1'b1;
    end
  end

  // next bit completes a byte that already has a full FCS window behind it
  assign byte_rdy_o = (ph_q == PH_W'(BYTE_W - 1)) &&
                      (cnt_q >= CNT_W'(BYTE_W + FCS_W - 1));

  for (genvar i = 0; i < BYTE_W; i++) begin : g_byte
    assign byte_o[i] = hist_q[HIST_W-1-i];
  end

  assign fcs_o      = hist_q[FCS_W-1:0];
  assign fcs_full_o = cnt_q >= CNT_W'(FCS_W);
  assign long_o     = cnt_q >= CNT_W'(MIN_BITS);
  assign aligned_o  = ph_q == '0;

endmodule

// File: rtl/hdlc_rx_crc.sv
// Serial reflected CRC with residue compare.
module hdlc_rx_crc #(
  parameter int          CRC_W   = 16,
  parameter logic [15:0] POLY    = 16'h8408,
  parameter logic [15:0] PRESET  = 16'hFFFF,
  parameter logic [15:0] RESIDUE = 16'hF0B8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic ok_o
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  always_comb begin
    fb    = crc_q[0] ^ bit_i;
    crc_d = (crc_q >> 1) ^ (fb ? POLY[CRC_W-1:0] : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= PRESET[CRC_W-1:0];
    else if (clr_i)   crc_q <= PRESET[CRC_W-1:0];
    else if (en_i)    crc_q <= crc_d;
  end

  assign ok_o = crc_q == RESIDUE[CRC_W-1:0];

endmodule

// File: rtl/hdlc_rx_ctrl.sv
// Frame sequencing, enable/disable timing, one-byte look-behind for tagging.
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              bit_vld_i,
  input  logic              flag_i,
  input  logic              abort_i,
  input  logic              byte_rdy_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              long_i,
  input  logic              aligned_i,
  input  logic              fcs_full_i,
  input  logic              crc_ok_i,
  output logic              clr_o,
  output logic              shift_o,
  output logic              cap_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [1:0]        tag_o
);
  rx_st_e            st_q, st_d;
  logic              wrote_q, wrote_d;
  logic              pend_vld_q, pend_vld_d;
  logic [BYTE_W-1:0] pend_q, pend_d;
  logic              emit;
  tag_e              etag;
  logic              frame_ok;

  logic              vld_q;
  logic [BYTE_W-1:0] byte_q;
  tag_e              tag_q;

  assign frame_ok = crc_ok_i && long_i && aligned_i;

  always_comb begin
    st_d       = st_q;
    wrote_d    = wrote_q;
    pend_vld_d = pend_vld_q;
    pend_d     = pend_q;
    clr_o      = 1'b0;
    shift_o    = 1'b0;
    cap_o      = 1'b0;
    emit       = 1'b0;
    etag       = TAG_MID;
    case (st_q)
      RX_OFF: begin
        if (rx_en_i) st_d = RX_HUNT;
      end
      RX_HUNT: begin
        if (!rx_en_i) begin
          st_d = RX_OFF;
        end else if (flag_i) begin
          st_d  = RX_FRAME;
          clr_o = 1'b1;
        end
      end
      RX_FRAME: begin
        if (!rx_en_i && !wrote_q) begin
          // nothing written yet: stop now, drop held bytes
          st_d       = RX_OFF;
          clr_o      = 1'b1;
          pend_vld_d = 1'b0;
        end else if (flag_i) begin
          clr_o      = 1'b1;
          cap_o      = fcs_full_i;
          emit       = wrote_q;
          etag       = frame_ok ? TAG_LAST_OK : TAG_LAST_BAD;
          wrote_d    = 1'b0;
          pend_vld_d = 1'b0;
          st_d       = rx_en_i ? RX_FRAME : RX_OFF;
        end else if (abort_i) begin
          clr_o      = 1'b1;
          emit       = wrote_q;
          etag       = TAG_LAST_BAD;
          wrote_d    = 1'b0;
          pend_vld_d = 1'b0;
          st_d       = rx_en_i ? RX_HUNT : RX_OFF;
        end else if (bit_vld_i) begin
          shift_o = 1'b1;
          if (byte_rdy_i) begin
            emit       = pend_vld_q;
            etag       = wrote_q ? TAG_MID : TAG_FIRST;
            wrote_d    = wrote_q | pend_vld_q;
            pend_d     = byte_i;
            pend_vld_d = 1'b1;
          end
        end
      end
      default: st_d = RX_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= RX_OFF;
      wrote_q    <= 1'b0;
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
      vld_q      <= 1'b0;
      byte_q     <= '0;
      tag_q      <= TAG_MID;
    end else begin
      st_q       <= st_d;
      wrote_q    <= wrote_d;
      pend_vld_q <= pend_vld_d;
      pend_q     <= pend_d;
      vld_q      <= emit;
      if (emit) begin
        byte_q <= pend_q;
        tag_q  <= etag;
      end
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;
  assign tag_o      = tag_q;

endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int FCS_W    = 16,
  parameter int MIN_BITS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              flag_i,
  input  logic              abort_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [1:0]        tag_o,
  output logic [FCS_W-1:0]  fcs_o
);
  logic              clr, shift, cap;
  logic              byte_rdy, fcs_full, long_frm, aligned, crc_ok;
  logic [BYTE_W-1:0] hold_byte;
  logic [FCS_W-1:0]  hold_fcs;
  logic [FCS_W-1:0]  fcs_q;

  hdlc_rx_hold #(
    .BYTE_W  (BYTE_W),
    .FCS_W   (FCS_W),
    .MIN_BITS(MIN_BITS)
  ) hold_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .shift_i   (shift),
    .bit_i     (bit_i),
    .byte_rdy_o(byte_rdy),
    .byte_o    (hold_byte),
    .fcs_o     (hold_fcs),
    .fcs_full_o(fcs_full),
    .long_o    (long_frm),
    .aligned_o (aligned)
  );

  hdlc_rx_crc #(
    .CRC_W  (FCS_W),
    .POLY   (CRC_POLY_REFL),
    .PRESET (CRC_PRESET),
    .RESIDUE(CRC_RESIDUE)
  ) crc_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .en_i  (shift),
    .bit_i (bit_i),
    .ok_o  (crc_ok)
  );

  hdlc_rx_ctrl #(
    .BYTE_W(BYTE_W)
  ) ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_en_i   (rx_en_i),
    .bit_vld_i (bit_vld_i),
    .flag_i    (flag_i),
    .abort_i   (abort_i),
    .byte_rdy_i(byte_rdy),
    .byte_i    (hold_byte),
    .long_i    (long_frm),
    .aligned_i (aligned),
    .fcs_full_i(fcs_full),
    .crc_ok_i  (crc_ok),
    .clr_o     (clr),
    .shift_o   (shift),
    .cap_o     (cap),
    .byte_vld_o(byte_vld_o),
    .byte_o    (byte_o),
    .tag_o     (tag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  fcs_q <= '0;
    else if (cap) fcs_q <= hold_fcs;
  end

  assign fcs_o = fcs_q;

endmodule

// File: rtl/hdlc_rx_frame_chk.sv
module hdlc_rx_frame_chk #(
  parameter int FCS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_vld_i,
  input logic             flag_i,
  input logic             abort_i,
  input logic             byte_vld_o,
  input logic [1:0]       tag_o,
  input logic [FCS_W-1:0] fcs_o
);
  logic in_pkt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_pkt <= 1'b0;
    else if (byte_vld_o) begin
      if (tag_o == 2'b01)     in_pkt <= 1'b1;
      else if (tag_o[1])      in_pkt <= 1'b0;
    end
  end

  assert_first_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o && tag_o == 2'b01) |-> !in_pkt);

  assert_body_inside_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o && tag_o != 2'b01) |-> in_pkt);

  assert_good_on_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o && tag_o == 2'b10) |-> $past(flag_i));

  assert_quiet_no_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_vld_i || flag_i || abort_i) |=> !byte_vld_o);

  assert_fcs_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i |=> $stable(fcs_o));

endmodule

bind hdlc_rx_frame hdlc_rx_frame_chk #(.FCS_W(FCS_W)) chk_i (.*);

// File: tb/hdlc_rx_frame_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_frame_tb_top;
  import hdlc_rx_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_en_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, flag_i = 1'b0, abort_i = 1'b0;
  logic        byte_vld_o;
  logic [7:0]  byte_o;
  logic [1:0]  tag_o;
  logic [15:0] fcs_o;

  int n_chk = 0, n_fail = 0;
  logic       bits[$];
  logic [9:0] got[$];
  logic [9:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  hdlc_rx_frame dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .bit_vld_i(bit_vld_i),
    .bit_i(bit_i), .flag_i(flag_i), .abort_i(abort_i), .byte_vld_o(byte_vld_o),
    .byte_o(byte_o), .tag_o(tag_o), .fcs_o(fcs_o)
  );

  always @(negedge clk_i) if (rst_ni && byte_vld_o) got.push_back({tag_o, byte_o});

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(int upto);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < upto; i++) begin
      logic fb = c[0] ^ bits[i];
      c = {1'b0, c[15:1]} ^ (fb ? 16'h8408 : 16'h0000);
    end
    return c;
  endfunction

  task automatic build_good(int n);
    logic [15:0] f;
    bits.delete();
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = 8'($urandom);
      for (int i = 0; i < 8; i++) bits.push_back(b[i]);
    end
    f = ~crc_of(bits.size());
    for (int i = 0; i < 16; i++) bits.push_back(f[i]);
  endtask

  function automatic logic [15:0] fcs_want();
    logic [15:0] f;
    int m = bits.size();
    for (int i = 0; i < 16; i++) f[15-i] = bits[m-16+i];
    return f;
  endfunction

  // expected FIFO writes for the current bit list ended by flag or abort
  task automatic model(bit by_abort);
    int m = bits.size();
    int r = (m >= 24) ? (m - 24) / 8 + 1 : 0;
    exp_q.delete();
    if (r >= 2) begin
      for (int k = 0; k < r; k++) begin
        logic [7:0] b;
        logic [1:0] t;
        for (int i = 0; i < 8; i++) b[i] = bits[8*k+i];
        if (k == 0)        t = TAG_FIRST;
        else if (k < r-1)  t = TAG_MID;
        else if (by_abort) t = TAG_LAST_BAD;
        else t = (m >= 32 && m % 8 == 0 && crc_of(m) == 16'hF0B8) ? TAG_LAST_OK : TAG_LAST_BAD;
        exp_q.push_back({t, b});
      end
    end
  endtask

  task automatic drive_bits(int drop_at);
    for (int i = 0; i < bits.size(); i++) begin
      if (i == drop_at) rx_en_i = 1'b0;
      repeat ($urandom % 3) @(negedge clk_i);
      bit_vld_i = 1'b1;
      bit_i     = bits[i];
      @(negedge clk_i);
      bit_vld_i = 1'b0;
    end
  endtask

  task automatic pulse_flag();
    flag_i = 1'b1;
    @(negedge clk_i);
    flag_i = 1'b0;
  endtask

  task automatic pulse_abort();
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
  endtask

  task automatic compare(string req);
    int n;
    repeat (4) @(negedge clk_i);
    check_eq(req, "write count", got.size(), exp_q.size());
    n = (got.size() < exp_q.size()) ? got.size() : exp_q.size();
    for (int i = 0; i < n; i++) check_eq(req, "tag+byte", 32'(got[i]), 32'(exp_q[i]));
    check_eq("R12", "idle strobe", 32'(byte_vld_o), 32'd0);
    got.delete();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] keep;
    logic [9:0]  save_q[$];
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    // R1: reset values
    check_eq("R1", "byte_vld_o", 32'(byte_vld_o), 0);
    check_eq("R1", "byte_o", 32'(byte_o), 0);
    check_eq("R1", "tag_o", 32'(tag_o), 0);
    check_eq("R1", "fcs_o", 32'(fcs_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: receiver off until enabled
    build_good(3);
    pulse_flag();
    drive_bits(-1);
    pulse_flag();
    exp_q.delete();
    compare("R1");

    rx_en_i = 1'b1;
    @(negedge clk_i);
    pulse_flag();

    // R2 R3 R10: minimum good frame
    build_good(2);
    drive_bits(-1);
    pulse_flag();
    model(0);
    compare("R3");
    check_eq("R10", "fcs capture", 32'(fcs_o), 32'(fcs_want()));

    // R4 R11: random frames sharing flags, some corrupted
    for (int f = 0; f < 30; f++) begin
      int n = 2 + int'($urandom % 10);
      bit bad = ($urandom % 4) == 0;
      build_good(n);
      if (bad) begin
        int idx = int'($urandom % (8 * n));
        bits[idx] = ~bits[idx];
      end
      drive_bits(-1);
      pulse_flag();
      model(0);
      compare(bad ? "R4" : "R11");
      check_eq("R10", "fcs capture", 32'(fcs_o), 32'(fcs_want()));
    end

    // R5: abort after bytes written, then hunt for flag
    build_good(6);
    bits = bits[0:43];
    drive_bits(-1);
    pulse_abort();
    model(1);
    compare("R5");
    build_good(4);
    drive_bits(-1);
    build_good(3);
    model(0);
    save_q = exp_q;
    pulse_flag();
    drive_bits(-1);
    pulse_flag();
    exp_q = save_q;
    compare("R5");

    // R6: short frame with valid CRC gives nothing
    build_good(1);
    drive_bits(-1);
    pulse_flag();
    exp_q.delete();
    compare("R6");
    // R6: 31 bits
    build_good(2);
    void'(bits.pop_back());
    drive_bits(-1);
    pulse_flag();
    exp_q.delete();
    compare("R6");
    // R6: not a byte multiple
    build_good(4);
    for (int i = 0; i < 3; i++) bits.push_back(1'b0);
    drive_bits(-1);
    pulse_flag();
    model(0);
    compare("R6");

    // R7: enable mid-frame
    rx_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rx_en_i = 1'b1;
    build_good(4);
    drive_bits(-1);
    build_good(2);
    model(0);
    save_q = exp_q;
    pulse_flag();
    drive_bits(-1);
    pulse_flag();
    exp_q = save_q;
    compare("R7");

    // R8: disable before any byte written
    keep = fcs_o;
    build_good(5);
    drive_bits(20);
    pulse_flag();
    exp_q.delete();
    compare("R8");
    check_eq("R8", "fcs untouched", 32'(fcs_o), 32'(keep));
    rx_en_i = 1'b1;
    @(negedge clk_i);
    pulse_flag();

    // R9: graceful disable after first write
    build_good(6);
    drive_bits(45);
    pulse_flag();
    model(0);
    compare("R9");
    build_good(3);
    drive_bits(-1);
    pulse_flag();
    exp_q.delete();
    compare("R9");

    finish_run();
  end

endmodule